// File: doc/BRIEF.md
# E3 Frame Alignment Alarm Supervisor

This block supervises frame alignment for the receive side of an E3 framer. An upstream detector looks for the frame alignment word and gives one strobe per frame, with a pass or fail flag. From those strobes the supervisor decides when the receiver is out of frame (OOF). It also times how long that state lasts and raises loss of frame (LOF) after a selectable number of milliseconds, counted from a 1 ms tick. Software can force a realignment with a rising edge on a control input. This makes the block act as though the latest alignment checks had all failed.

The block also builds the request for the remote alarm bit in the outgoing frame. LOF, loss of signal (LOS), OOF and the alarm indication signal (AIS) can each be included or left out on its own. The whole request is gated by an automatic-alarm enable. All outputs are registered on the receive clock and cleared by a synchronous active-high reset.

Top module: `e3_align_supervisor`

## Requirements
- R1: OOF rises one clock after the strobe that completes 4 consecutive failed checks (`chk_valid`=1, `chk_ok`=0) while aligned. A passing strobe restarts the run. Cycles without a strobe change nothing.
- R2: While OOF, the flag clears one clock after the second consecutive passing strobe. A failing strobe between the two restarts the count.
- R3: A 0-to-1 change on `resync` sets OOF one clock later. Holding `resync` high does not force OOF again. Another forced realignment needs `resync` to go low and then high.
- R4: With `lof_period` = 2'b11, LOF rises in the same clock as OOF.
- R5: With `lof_period` = 2'b10, 2'b01 or 2'b00, LOF rises one clock after the 1st, 2nd or 3rd `tick_1ms` pulse seen while OOF is already high.
- R6: LOF falls in the same clock that OOF falls. The millisecond count restarts from zero, so a new OOF episode needs the full period again.
- R7: One clock after its inputs, `a_bit_req` equals `auto_rai_en` AND the OR of (LOF and `lof_rai_en`), (`los_in` and not `los_rai_dis`), (OOF and not `oof_rai_dis`) and (`ais_in` and not `ais_rai_dis`).
- R8: While `rst` is high at a clock edge, `oof`, `lof` and `a_bit_req` are cleared to 0.
- R9: LOF is never high while OOF is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous reset, active high |
| chk_valid | input | 1 | One-cycle strobe: an alignment check result is present |
| chk_ok | input | 1 | Check result: 1 = alignment word correct, 0 = failed |
| tick_1ms | input | 1 | One-cycle pulse every millisecond |
| los_in | input | 1 | Loss of signal status |
| ais_in | input | 1 | Alarm indication signal status |
| lof_period | input | 2 | LOF delay: 00 = 3 ms, 01 = 2 ms, 10 = 1 ms, 11 = immediate |
| resync | input | 1 | Forced realignment; acts on its rising edge |
| lof_rai_en | input | 1 | 1 = LOF drives the alarm bit |
| los_rai_dis | input | 1 | 1 = LOS left out of the alarm bit |
| oof_rai_dis | input | 1 | 1 = OOF left out of the alarm bit |
| ais_rai_dis | input | 1 | 1 = AIS left out of the alarm bit |
| auto_rai_en | input | 1 | Master enable of the automatic alarm bit |
| oof | output | 1 | Out-of-frame status |
| lof | output | 1 | Loss-of-frame status |
| a_bit_req | output | 1 | Request to set the remote alarm bit in the transmit frame |

## Verification
A wrong failure or pass count would move the OOF edge by at least one strobe. The bench sees that on the first check after the 4th failure or the 2nd pass. A millisecond timer that is not cleared on exit from OOF would show up as LOF one or more ticks early in the next episode. A wrong edge detector on `resync` would either miss the forced OOF or repeat it while the control stays high. Both are visible within two clocks. Faults in the alarm gating appear on `a_bit_req` one clock after the matching status or control input changes.

// File: rtl/e3sup_pkg.sv
package e3sup_pkg;

  // Encoding of the LOF delay selector.
  typedef enum logic [1:0] {
    LOF_DLY_3MS = 2'b00,
    LOF_DLY_2MS = 2'b01,
    LOF_DLY_1MS = 2'b10,
    LOF_DLY_0MS = 2'b11
  } lof_dly_e;

  // Number of millisecond ticks that OOF must last before LOF is declared.
  function automatic int unsigned lof_dly_ms(lof_dly_e code);
    case (code)
      LOF_DLY_3MS: lof_dly_ms = 3;
      LOF_DLY_2MS: lof_dly_ms = 2;
      LOF_DLY_1MS: lof_dly_ms = 1;
      default:     lof_dly_ms = 0;
    endcase
  endfunction

endpackage

// File: rtl/e3sup_oof_tracker.sv
module e3sup_oof_tracker #(
  parameter int unsigned FAIL_RUN = 4,
  parameter int unsigned PASS_RUN = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic chk_valid,
  input  logic chk_ok,
  input  logic resync,
  output logic oof,
  output logic oof_next
);

  localparam int unsigned FW = $clog2(FAIL_RUN + 1);
  localparam int unsigned PW = $clog2(PASS_RUN + 1);

  logic [FW-1:0] fail_cnt, fail_n;
  logic [PW-1:0] pass_cnt, pass_n;
  logic          resync_q;
  logic          resync_edge;

  assign resync_edge = resync & ~resync_q;

  always_comb begin
    fail_n   = fail_cnt;
    pass_n   = pass_cnt;
    oof_next = oof;
    if (resync_edge) begin
      // A forced realignment behaves like a full run of failed checks.
      oof_next = 1'b1;
      fail_n   = FW'(FAIL_RUN);
      pass_n   = '0;
    end else if (chk_valid) begin
      if (!oof) begin
        if (chk_ok) begin
          fail_n = '0;
        end else if (fail_cnt == FW'(FAIL_RUN - 1)) begin
          oof_next = 1'b1;
          fail_n   = FW'(FAIL_RUN);
          pass_n   = '0;
        end else begin
          fail_n = fail_cnt + 1'b1;
        end
      end else begin
        if (!chk_ok) begin
          pass_n = '0;
        end else if (pass_cnt == PW'(PASS_RUN - 1)) begin
          oof_next = 1'b0;
          pass_n   = '0;
          fail_n   = '0;
        end else begin
          pass_n = pass_cnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fail_cnt <= '0;
      pass_cnt <= '0;
      resync_q <= 1'b0;
      oof      <= 1'b0;
    end else begin
      fail_cnt <= fail_n;
      pass_cnt <= pass_n;
      resync_q <= resync;
      oof      <= oof_next;
    end
  end

endmodule

// File: rtl/e3sup_lof_timer.sv
module e3sup_lof_timer
  import e3sup_pkg::*;
#(
  parameter int unsigned MS_W = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     oof,
  input  logic     oof_next,
  input  logic     tick_1ms,
  input  lof_dly_e period,
  output logic     lof
);

  logic [MS_W-1:0] ms_cnt;
  logic [MS_W-1:0] target;
  logic [MS_W-1:0] ms_inc;

  assign target = MS_W'(lof_dly_ms(period));
  assign ms_inc = ms_cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      ms_cnt <= '0;
      lof    <= 1'b0;
    end else if (!oof_next) begin
      // Leaving (or staying out of) OOF clears both the timer and LOF.
      ms_cnt <= '0;
      lof    <= 1'b0;
    end else if (target == '0) begin
      lof <= 1'b1;
    end else if (oof && tick_1ms && !lof) begin
      ms_cnt <= ms_inc;
      if (ms_inc >= target) begin
        lof <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/e3sup_rai_gate.sv
module e3sup_rai_gate #(
  parameter int unsigned NCOND = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             auto_en,
  input  logic [NCOND-1:0] cond,
  input  logic [NCOND-1:0] cond_en,
  output logic             a_req
);

  logic [NCOND-1:0] hit;

  for (genvar i = 0; i < NCOND; i++) begin : g_mask
    assign hit[i] = cond[i] & cond_en[i];
  end

  always_ff @(posedge clk) begin
    if (rst) a_req <= 1'b0;
    else     a_req <= auto_en & (|hit);
  end

endmodule

// File: rtl/e3_align_supervisor.sv
module e3_align_supervisor
  import e3sup_pkg::*;
#(
  parameter int unsigned FAIL_RUN = 4,
  parameter int unsigned PASS_RUN = 2,
  parameter int unsigned MS_W     = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       chk_valid,
  input  logic       chk_ok,
  input  logic       tick_1ms,
  input  logic       los_in,
  input  logic       ais_in,
  input  logic [1:0] lof_period,
  input  logic       resync,
  input  logic       lof_rai_en,
  input  logic       los_rai_dis,
  input  logic       oof_rai_dis,
  input  logic       ais_rai_dis,
  input  logic       auto_rai_en,
  output logic       oof,
  output logic       lof,
  output logic       a_bit_req
);

  localparam int unsigned NCOND = 4;

  logic             oof_next;
  logic [NCOND-1:0] cond;
  logic [NCOND-1:0] cond_en;

  e3sup_oof_tracker #(
    .FAIL_RUN(FAIL_RUN),
    .PASS_RUN(PASS_RUN)
  ) u_oof (
    .clk      (clk),
    .rst      (rst),
    .chk_valid(chk_valid),
    .chk_ok   (chk_ok),
    .resync   (resync),
    .oof      (oof),
    .oof_next (oof_next)
  );

  e3sup_lof_timer #(
    .MS_W(MS_W)
  ) u_lof (
    .clk     (clk),
    .rst     (rst),
    .oof     (oof),
    .oof_next(oof_next),
    .tick_1ms(tick_1ms),
    .period  (lof_dly_e'(lof_period)),
    .lof     (lof)
  );

  assign cond    = {lof, los_in, oof, ais_in};
  assign cond_en = {lof_rai_en, ~los_rai_dis, ~oof_rai_dis, ~ais_rai_dis};

  e3sup_rai_gate #(
    .NCOND(NCOND)
  ) u_rai (
    .clk    (clk),
    .rst    (rst),
    .auto_en(auto_rai_en),
    .cond   (cond),
    .cond_en(cond_en),
    .a_req  (a_bit_req)
  );

endmodule

// File: rtl/e3_align_supervisor_chk.sv
module e3_align_supervisor_chk (
  input logic       clk,
  input logic       rst,
  input logic       resync,
  input logic [1:0] lof_period,
  input logic       los_in,
  input logic       los_rai_dis,
  input logic       auto_rai_en,
  input logic       oof,
  input logic       lof,
  input logic       a_bit_req
);

  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  p_lof_needs_oof_r9: assert property (@(posedge clk) disable iff (rst)
    lof |-> oof);

  p_lof_drops_with_oof_r6: assert property (@(posedge clk) disable iff (rst)
    (armed && $fell(oof)) |-> !lof);

  p_lof_immediate_r4: assert property (@(posedge clk) disable iff (rst)
    (armed && $rose(oof) && $past(lof_period) == 2'b11) |-> lof);

  p_resync_forces_oof_r3: assert property (@(posedge clk) disable iff (rst)
    (armed && $rose(resync)) |=> oof);

  p_auto_off_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(auto_rai_en)) |-> !a_bit_req);

  p_los_drives_abit_r7: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(auto_rai_en && los_in && !los_rai_dis)) |-> a_bit_req);

endmodule

bind e3_align_supervisor e3_align_supervisor_chk u_chk (.*);

// File: tb/sim_e3_align_supervisor.sv
module sim_e3_align_supervisor;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       chk_valid = 1'b0, chk_ok = 1'b0, tick_1ms = 1'b0;
  logic       los_in = 1'b0, ais_in = 1'b0;
  logic [1:0] lof_period = 2'b00;
  logic       resync = 1'b0;
  logic       lof_rai_en = 1'b0, los_rai_dis = 1'b0, oof_rai_dis = 1'b0;
  logic       ais_rai_dis = 1'b0, auto_rai_en = 1'b0;
  logic       oof, lof, a_bit_req;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  e3_align_supervisor u0 (
    .clk(clk), .rst(rst), .chk_valid(chk_valid), .chk_ok(chk_ok),
    .tick_1ms(tick_1ms), .los_in(los_in), .ais_in(ais_in),
    .lof_period(lof_period), .resync(resync), .lof_rai_en(lof_rai_en),
    .los_rai_dis(los_rai_dis), .oof_rai_dis(oof_rai_dis),
    .ais_rai_dis(ais_rai_dis), .auto_rai_en(auto_rai_en),
    .oof(oof), .lof(lof), .a_bit_req(a_bit_req)
  );

  task automatic chk(string req, string what, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(logic ok);
    chk_valid = 1'b1;
    chk_ok    = ok;
    @(negedge clk);
    chk_valid = 1'b0;
  endtask

  task automatic tick();
    tick_1ms = 1'b1;
    @(negedge clk);
    tick_1ms = 1'b0;
  endtask

  task automatic fails(int n);
    for (int i = 0; i < n; i++) strobe(1'b0);
  endtask

  task automatic realign();
    strobe(1'b1);
    strobe(1'b1);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    idle(3);
    chk("R8", "oof in reset", oof, 1'b0);
    chk("R8", "lof in reset", lof, 1'b0);
    chk("R8", "a_bit in reset", a_bit_req, 1'b0);
    rst = 1'b0;
    idle(2);
  endtask

  task automatic t_oof_entry_exit();
    lof_period = 2'b00;
    fails(3);
    chk("R1", "oof after 3 fails", oof, 1'b0);
    strobe(1'b1);
    fails(3);
    idle(4);
    chk("R1", "oof after pass broke run", oof, 1'b0);
    fails(1);
    chk("R1", "oof after 4th fail", oof, 1'b1);
    strobe(1'b1);
    chk("R2", "oof after 1 pass", oof, 1'b1);
    strobe(1'b0);
    strobe(1'b1);
    chk("R2", "oof after fail broke pass run", oof, 1'b1);
    strobe(1'b1);
    chk("R2", "oof after 2 passes", oof, 1'b0);
    chk("R9", "lof stays low without ticks", lof, 1'b0);
  endtask

  task automatic t_lof_immediate();
    lof_period = 2'b11;
    fails(3);
    chk("R4", "lof before oof", lof, 1'b0);
    fails(1);
    chk("R4", "oof with code 11", oof, 1'b1);
    chk("R4", "lof same cycle as oof", lof, 1'b1);
    strobe(1'b1);
    strobe(1'b1);
    chk("R6", "oof cleared", oof, 1'b0);
    chk("R6", "lof cleared with oof", lof, 1'b0);
  endtask

  task automatic t_lof_timed();
    lof_period = 2'b10;
    fails(4);
    chk("R5", "1ms: lof before tick", lof, 1'b0);
    tick();
    chk("R5", "1ms: lof after 1 tick", lof, 1'b1);
    realign();
    lof_period = 2'b01;
    fails(4);
    tick();
    chk("R5", "2ms: lof after 1 tick", lof, 1'b0);
    tick();
    chk("R5", "2ms: lof after 2 ticks", lof, 1'b1);
    realign();
    lof_period = 2'b00;
    fails(4);
    tick();
    tick();
    chk("R5", "3ms: lof after 2 ticks", lof, 1'b0);
    realign();
    chk("R6", "oof cleared mid count", oof, 1'b0);
    idle(2);
    tick();
    chk("R9", "tick while aligned keeps lof low", lof, 1'b0);
    fails(4);
    tick();
    tick();
    chk("R6", "timer restarted: lof after 2 ticks", lof, 1'b0);
    tick();
    chk("R5", "3ms: lof after 3 ticks", lof, 1'b1);
    realign();
    chk("R6", "lof cleared", lof, 1'b0);
  endtask

  task automatic t_resync();
    lof_period = 2'b00;
    resync = 1'b1;
    @(negedge clk);
    chk("R3", "oof after resync edge", oof, 1'b1);
    realign();
    idle(4);
    chk("R3", "held resync does not retrigger", oof, 1'b0);
    resync = 1'b0;
    idle(2);
    chk("R3", "falling resync has no effect", oof, 1'b0);
    resync = 1'b1;
    @(negedge clk);
    chk("R3", "oof after second edge", oof, 1'b1);
    resync = 1'b0;
    realign();
    chk("R3", "cleared after resync", oof, 1'b0);
  endtask

  task automatic t_rai();
    lof_period = 2'b00;
    auto_rai_en = 1'b1;
    los_in = 1'b1;
    @(negedge clk);
    chk("R7", "los drives a_bit", a_bit_req, 1'b1);
    los_rai_dis = 1'b1;
    @(negedge clk);
    chk("R7", "los disabled", a_bit_req, 1'b0);
    ais_in = 1'b1;
    @(negedge clk);
    chk("R7", "ais drives a_bit", a_bit_req, 1'b1);
    ais_rai_dis = 1'b1;
    @(negedge clk);
    chk("R7", "ais disabled", a_bit_req, 1'b0);
    fails(4);
    idle(1);
    chk("R7", "oof drives a_bit", a_bit_req, 1'b1);
    oof_rai_dis = 1'b1;
    @(negedge clk);
    chk("R7", "oof disabled", a_bit_req, 1'b0);
    tick(); tick(); tick();
    idle(1);
    chk("R7", "lof without enable", a_bit_req, 1'b0);
    lof_rai_en = 1'b1;
    @(negedge clk);
    chk("R7", "lof enabled drives a_bit", a_bit_req, 1'b1);
    auto_rai_en = 1'b0;
    @(negedge clk);
    chk("R7", "auto off masks all", a_bit_req, 1'b0);
    realign();
    auto_rai_en = 1'b1;
    @(negedge clk);
    chk("R7", "no condition after realign", a_bit_req, 1'b0);
  endtask

  initial begin
    t_reset();
    t_oof_entry_exit();
    t_lof_immediate();
    t_lof_timed();
    t_resync();
    t_rai();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule